// File: doc/BRIEF.md
# Modem Status Edge Interrupt Unit

This block watches the four modem status inputs of a serial port: clear-to-send, carrier detect, ring indicator and data-set-ready. Each input passes through a two-flop synchronizer. The synchronized levels can be read at any time from a status register.

Clear-to-send and carrier detect also have edge detectors. Each detector latches a sticky status flag. By default only a rising edge sets a flag. A per-line "any edge" option makes both rising and falling edges set it. Reading the status register returns the flags and clears them in the same access. An edge seen in the same cycle as that read is kept, so it shows up on the next read.

The interrupt request is registered. It rises when a latched flag has its line enable set and the master interrupt mask is on. The same small register port also holds the data-terminal-ready and request-to-send controls. These drive their pins inverted, so writing a 1 pulls the pin low.

Top module: `mdm_edge_irq`

## Requirements
- R1: Status register (address 0) read data carries the synchronized levels: bit 0 clear-to-send, bit 1 carrier detect, bit 2 ring indicator, bit 3 data-set-ready. Read data appears with `rd_valid` one cycle after the `rd_en` cycle.
- R2: With the line's any-edge bit clear, a rising edge sets the status flag (bit 4 for clear-to-send, bit 5 for carrier detect) and a falling edge does not.
- R3: With the line's any-edge bit set (config bit 2 for clear-to-send, bit 3 for carrier detect), both rising and falling edges set the flag.
- R4: A read of address 0 returns the flags as they were before the read and clears them.
- R5: An edge detected in the same cycle as a status read is not lost: the read returns the old flag and the next read returns it set.
- R6: `ext_irq` rises when a flag is set whose enable is on (config bit 0 clear-to-send, bit 1 carrier detect) and the master mask (config bit 4) is on. It falls once the flags are cleared by a read.
- R7: A flag whose enable is off still latches but does not raise `ext_irq`.
- R8: With the master mask off, `ext_irq` stays low. Turning the mask on while an enabled flag is pending raises it.
- R9: The output register (address 2) has bit 0 for data-terminal-ready and bit 1 for request-to-send. Each pin carries the inverse of its bit, and the register reads back as written.
- R10: After reset, all flags and configuration are zero, both pins are high and `ext_irq` is low.
- R11: The config register (address 1) reads back as written. A write to address 0 has no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_i | input | 1 | Clear-to-send input, asynchronous |
| dcd_i | input | 1 | Carrier-detect input, asynchronous |
| ri_i | input | 1 | Ring-indicator input, asynchronous |
| dsr_i | input | 1 | Data-set-ready input, asynchronous |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Register address |
| wr_data | input | DW | Write data |
| rd_data | output | DW | Registered read data |
| rd_valid | output | 1 | High for one cycle when rd_data holds read data |
| dtr_n_o | output | 1 | Data-terminal-ready pin, inverse of control bit |
| rts_n_o | output | 1 | Request-to-send pin, inverse of control bit |
| ext_irq | output | 1 | Registered external-input interrupt request |

## Verification
The hardest case is an edge whose detection lands in the exact cycle of a status read. A design that gave the clear priority over the set would drop that event, and the second read would come back empty. The bench also drives falling edges with the any-edge option off and then on. A detector wired for a single polarity would either set a flag it must not set or miss a falling edge. Further cases are a pending flag that only becomes an interrupt when the master mask is turned on, a flag latched with its enable off, and a write to the status address. A design with the pin polarity not inverted, or one that cleared flags on any write, would show a wrong pin level or an empty flag in the next read.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  // register addresses
  localparam int ADDR_STAT = 0;
  localparam int ADDR_CFG  = 1;
  localparam int ADDR_OUT  = 2;

  // status register layout
  localparam int LVL_W     = 4;
  localparam int EDGE_N    = 2;
  localparam int ST_LSB    = 4;

  // output register layout
  localparam int OUT_DTR   = 0;
  localparam int OUT_RTS   = 1;

  // configuration register: mask bit4, any-edge bits3:2, enables bits1:0
  typedef struct packed {
    logic                 mask;
    logic [EDGE_N-1:0]    any_edge;
    logic [EDGE_N-1:0]    en;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mdm_edge_latch.sv
module mdm_edge_latch (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic any_edge,
  input  logic clr,
  output logic stat
);
  logic prev_q;
  logic rise, fall, set_ev;

  assign rise   = lvl & ~prev_q;
  assign fall   = ~lvl & prev_q;
  assign set_ev = rise | (any_edge & fall);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      stat   <= 1'b0;
    end else begin
      prev_q <= lvl;
      // a new event wins over the clear of the same cycle
      stat   <= set_ev | (stat & ~clr);
    end
  end

  // R4
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !set_ev) |=> !stat);
  // R5
  edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
    set_ev |=> stat);
  // R2
  rise_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!stat && !any_edge && $fell(lvl)) |=> !stat);
  // R3
  any_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (any_edge && ($rose(lvl) || $fell(lvl))) |=> stat);
endmodule

// File: rtl/mdm_regs.sv
module mdm_regs
  import mdm_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [LVL_W-1:0]  lvl,
  input  logic [EDGE_N-1:0] stat,
  output cfg_t              cfg,
  output logic              stat_clr,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid,
  output logic              dtr_n_o,
  output logic              rts_n_o
);
  logic          sel_stat, sel_cfg, sel_out;
  logic [DW-1:0] rd_next;
  logic          unused_wr_hi;

  assign sel_stat = (addr == AW'(ADDR_STAT));
  assign sel_cfg  = (addr == AW'(ADDR_CFG));
  assign sel_out  = (addr == AW'(ADDR_OUT));
  assign stat_clr = rd_en & sel_stat;
  assign unused_wr_hi = ^wr_data[DW-1:CFG_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg     <= '0;
      dtr_n_o <= 1'b1;
      rts_n_o <= 1'b1;
    end else if (wr_en) begin
      if (sel_cfg) cfg <= cfg_t'(wr_data[CFG_W-1:0]);
      if (sel_out) begin
        dtr_n_o <= ~wr_data[OUT_DTR];
        rts_n_o <= ~wr_data[OUT_RTS];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (sel_stat) begin
      rd_next[LVL_W-1:0]             = lvl;
      rd_next[ST_LSB +: EDGE_N]      = stat;
    end else if (sel_cfg) begin
      rd_next[CFG_W-1:0]             = cfg;
    end else if (sel_out) begin
      rd_next[OUT_DTR]               = ~dtr_n_o;
      rd_next[OUT_RTS]               = ~rts_n_o;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_next;
    end
  end

  // R9
  dtr_pin_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel_out) |=> (dtr_n_o == !$past(wr_data[OUT_DTR])));
  // R11
  cfg_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && sel_cfg) |=> $stable(cfg));
endmodule

// File: rtl/mdm_irq.sv
module mdm_irq
  import mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [EDGE_N-1:0] stat,
  input  logic [EDGE_N-1:0] en,
  input  logic              mask,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= mask & (|(stat & en));
  end

  // R8
  mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !mask |=> !irq);
  // R7
  en_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ((stat & en) == '0) |=> !irq);
endmodule

// File: rtl/mdm_edge_irq.sv
module mdm_edge_irq
  import mdm_pkg::*;
#(
  parameter int DW          = 8,
  parameter int AW          = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cts_i,
  input  logic          dcd_i,
  input  logic          ri_i,
  input  logic          dsr_i,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          dtr_n_o,
  output logic          rts_n_o,
  output logic          ext_irq
);
  logic [LVL_W-1:0]  raw_lvl, lvl;
  logic [EDGE_N-1:0] stat;
  logic              stat_clr;
  cfg_t              cfg;

  assign raw_lvl = {dsr_i, ri_i, dcd_i, cts_i};

  mdm_sync #(.W(LVL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .d (raw_lvl), .q (lvl)
  );

  for (genvar g = 0; g < EDGE_N; g++) begin : g_edge
    mdm_edge_latch u_latch (
      .clk      (clk),
      .rst      (rst),
      .lvl      (lvl[g]),
      .any_edge (cfg.any_edge[g]),
      .clr      (stat_clr),
      .stat     (stat[g])
    );
  end

  mdm_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .lvl      (lvl),
    .stat     (stat),
    .cfg      (cfg),
    .stat_clr (stat_clr),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .dtr_n_o  (dtr_n_o),
    .rts_n_o  (rts_n_o)
  );

  mdm_irq u_irq (
    .clk  (clk),
    .rst  (rst),
    .stat (stat),
    .en   (cfg.en),
    .mask (cfg.mask),
    .irq  (ext_irq)
  );

  // R6
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stat == '0) |=> !ext_irq);
endmodule

// File: tb/mdm_edge_irq_tb.sv
module mdm_edge_irq_tb;
  logic       clk = 0;
  logic       rst = 1;
  logic       cts_i = 0, dcd_i = 0, ri_i = 0, dsr_i = 0;
  logic       wr_en = 0, rd_en = 0;
  logic [1:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       rd_valid, dtr_n_o, rts_n_o, ext_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;

  mdm_edge_irq u_dut (
    .clk(clk), .rst(rst), .cts_i(cts_i), .dcd_i(dcd_i), .ri_i(ri_i),
    .dsr_i(dsr_i), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .dtr_n_o(dtr_n_o), .rts_n_o(rts_n_o), .ext_irq(ext_irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when read data comes out
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) check("unexpected read data", rd_data, 8'hxx);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  // driver tasks: called at a falling edge, return at a falling edge
  task automatic do_read(input logic [1:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    check("R10 dtr pin", {7'b0, dtr_n_o}, 8'h01);
    check("R10 rts pin", {7'b0, rts_n_o}, 8'h01);
    check("R10 irq", {7'b0, ext_irq}, 8'h00);
    do_read(2'd0, 8'h00, "R10 status");
    do_read(2'd1, 8'h00, "R10 config");
    do_read(2'd2, 8'h00, "R10 outputs");

    // R1 levels of lines without edge flags
    ri_i = 1; dsr_i = 1; settle();
    do_read(2'd0, 8'h0C, "R1 ri/dsr levels");

    // R11 config readback
    do_write(2'd1, 8'h13);
    do_read(2'd1, 8'h13, "R11 config readback");

    // R2/R6/R4 rising cts
    cts_i = 1; settle();
    check("R6 irq on enabled flag", {7'b0, ext_irq}, 8'h01);
    do_read(2'd0, 8'h1D, "R2 cts rise flag");
    @(negedge clk);
    check("R6 irq after clear", {7'b0, ext_irq}, 8'h00);
    do_read(2'd0, 8'h0D, "R4 flag cleared by read");

    // R2 falling edge ignored without any-edge
    cts_i = 0; settle();
    do_read(2'd0, 8'h0C, "R2 cts fall ignored");

    // R3 any-edge mode
    do_write(2'd1, 8'h17);
    cts_i = 1; settle();
    do_read(2'd0, 8'h1D, "R3 cts rise any-edge");
    cts_i = 0; settle();
    do_read(2'd0, 8'h1C, "R3 cts fall any-edge");

    // R2 carrier detect rise
    dcd_i = 1; settle();
    do_read(2'd0, 8'h2E, "R2 dcd rise flag");

    // R7 enable off
    do_write(2'd1, 8'h15);
    dcd_i = 0; settle();
    dcd_i = 1; settle();
    check("R7 no irq with enable off", {7'b0, ext_irq}, 8'h00);
    do_read(2'd0, 8'h2E, "R7 flag latched with enable off");

    // R8 master mask
    do_write(2'd1, 8'h03);
    cts_i = 1; settle();
    check("R8 no irq with mask off", {7'b0, ext_irq}, 8'h00);
    do_write(2'd1, 8'h13);
    @(negedge clk);
    check("R8 irq after mask on", {7'b0, ext_irq}, 8'h01);
    do_read(2'd0, 8'h1F, "R8 pending flag");
    @(negedge clk);
    check("R8 irq cleared", {7'b0, ext_irq}, 8'h00);

    // R5 edge in the read cycle
    cts_i = 0; settle();
    do_read(2'd0, 8'h0E, "R5 setup");
    cts_i = 1;
    @(negedge clk);
    @(negedge clk);
    do_read(2'd0, 8'h0F, "R5 read in edge cycle");
    do_read(2'd0, 8'h1F, "R5 edge kept");
    do_read(2'd0, 8'h0F, "R5 cleared afterwards");

    // R11 write to status ignored
    do_write(2'd1, 8'h17);
    cts_i = 0; settle();
    do_write(2'd0, 8'h00);
    do_read(2'd0, 8'h1E, "R11 status write ignored");

    // R9 pins
    do_write(2'd2, 8'h01);
    check("R9 dtr low", {7'b0, dtr_n_o}, 8'h00);
    check("R9 rts high", {7'b0, rts_n_o}, 8'h01);
    do_write(2'd2, 8'h03);
    do_read(2'd2, 8'h03, "R9 readback");
    check("R9 rts low", {7'b0, rts_n_o}, 8'h00);
    do_write(2'd2, 8'h02);
    check("R9 dtr high again", {7'b0, dtr_n_o}, 8'h01);

    repeat (3) @(negedge clk);
    check("scoreboard drained", 8'(exp_q.size()), 8'h00);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule